// File: doc/BRIEF.md
# Asynchronous Microprocessor Slave Port with Channel Interrupt Queue

This block sits between an external microprocessor and the internal logic of a multi-channel device. The processor reaches it through an 11-bit address, an 8-bit data path and three control inputs: an active-low select, an active-low strobe and a direction line. The bus is asynchronous to the block clock. Select and strobe pass through two synchronising flops. An access begins when both are seen low. The block completes the access and answers with an active-low, open-drain acknowledge, and holds that acknowledge until the processor lifts the strobe. The block contains the main control register, and one bit of that register gates the device's serial output drivers.

Per-channel interrupt events arrive as single-cycle pulses, each carrying a 3-bit channel number. They are queued in a 16-entry FIFO, and the processor drains that FIFO by reading one register. An open-drain, active-low interrupt request is pulled low while at least one entry is waiting. It is released only when the last queued entry has been read.

Open-drain outputs are modelled as pull enables: a 1 on `ack_pull_lo` or `irq_pull_lo` means the pin is driven low, and a 0 means it is released. The bidirectional data bus is split into `bus_wdata`, `bus_rdata` and an output enable `bus_rdata_oe`.

Top module: `mcu_slave_port`

## Requirements
- R1: After reset, acknowledge, interrupt request and the data output enable are all released, `drive_en` is 0, and the control register (address 0x000) reads 0x00.
- R2: Once both `cs_n` and `ds_n` are low, the acknowledge is asserted on the fourth rising clock edge, and not before. This is two edges of synchronisation followed by two cycles of delay after detection.
- R3: Once asserted, the acknowledge is released within three clock edges of the strobe going high. While the strobe stays low, no second access takes place.
- R4: No access happens unless `cs_n` and `ds_n` are both low. If the strobe is low while select is high, there is no acknowledge, and a write has no effect.
- R5: A write (`rd_wr`=0) to address 0x000 stores the byte in the control register, and a later read (`rd_wr`=1) returns it. Any address other than 0x000 and 0x001 reads 0x00, and writes to such an address are ignored.
- R6: `drive_en` equals `ode_pin` AND bit 6 of the control register.
- R7: `bus_rdata_oe` is high only during a read access that has been acknowledged while `cs_n` and `ds_n` are both still low. It is never high during a write.
- R8: An event pulse is queued and pulls the interrupt request low from the next clock edge. Reading address 0x001 returns entries in arrival order, each as {bit7 = 1 (valid), bits 6:3 = 0, bits 2:0 = channel}.
- R9: The interrupt request stays asserted until the last queued entry has been read. Reading address 0x001 while the queue is empty returns 0x00.
- R10: The queue holds 16 entries, and an event arriving while the queue is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| ds_n | input | 1 | Active-low data strobe (asynchronous) |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 11 | Register address |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data to the processor |
| bus_rdata_oe | output | 1 | Data bus output enable |
| ack_pull_lo | output | 1 | 1 pulls the open-drain acknowledge low |
| irq_pull_lo | output | 1 | 1 pulls the open-drain interrupt request low |
| evt_valid | input | 1 | Single-cycle interrupt event pulse |
| evt_chan | input | 3 | Channel number of the event |
| ode_pin | input | 1 | External output-drive enable |
| drive_en | output | 1 | Combined output-drive enable |

## Verification
The bench counts the clock edges from strobe-low to acknowledge. A handshake that skipped a synchroniser stage or the delay would answer early, and one that added a stage would answer late. It holds the strobe low after an acknowledge and then reads the queue again. A design that retriggered on a held strobe would pop a second entry, and the next value read would come out one entry too far. It fills the queue past 16 and drains it completely. An overflow that overwrote an entry would show up as a wrong channel in the drained sequence. A wrong empty or release condition would show up as an interrupt released early, or as a stale byte in place of 0x00. It also drives the strobe with select high and writes to unmapped addresses, then reads the control register back; decode that ignored select or the address would have corrupted it.

// File: rtl/mcu_port_pkg.sv
package mcu_port_pkg;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int CHAN_W = 3;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 11'h000;
  localparam logic [ADDR_W-1:0] IRQQ_ADDR = 11'h001;
  localparam int ODE_BIT = 6;
  localparam int VALID_BIT = DATA_W - 1;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/mcu_port_sync.sv
module mcu_port_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;
endmodule

// File: rtl/mcu_port_irq_fifo.sv
module mcu_port_irq_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head_data,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             do_push, do_pop;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
    if (do_push && !do_pop)      count_d = count_q + 1'b1;
    else if (do_pop && !do_push) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data;
  end

  assign head_data = mem_q[rd_ptr_q];

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full && $stable(wr_ptr_q));
endmodule

// File: rtl/mcu_port_handshake.sv
module mcu_port_handshake
  import mcu_port_pkg::*;
#(
  parameter int ACK_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_s,
  output logic access_go,
  output logic ack_on
);
  localparam int CNT_W = $clog2(ACK_DLY + 1);

  hs_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    access_go = 1'b0;
    unique case (state_q)
      HS_IDLE: begin
        if (strobe_s) begin
          state_d = HS_WAIT;
          cnt_d   = CNT_W'(1);
        end
      end
      HS_WAIT: begin
        if (!strobe_s) begin
          state_d = HS_IDLE;
        end else if (cnt_q >= CNT_W'(ACK_DLY - 1)) begin
          state_d   = HS_ACK;
          access_go = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      HS_ACK: begin
        if (!strobe_s) state_d = HS_IDLE;
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ack_on = (state_q == HS_ACK);

  // R2
  ack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_on) |-> $past(strobe_s, 1) && $past(strobe_s, 2));

  // R3
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_on && !strobe_s) |=> !ack_on);
endmodule

// File: rtl/mcu_slave_port.sv
module mcu_slave_port
  import mcu_port_pkg::*;
#(
  parameter int IRQ_DEPTH = 16,
  parameter int ACK_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ds_n,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  output logic              ack_pull_lo,
  output logic              irq_pull_lo,
  input  logic              evt_valid,
  input  logic [CHAN_W-1:0] evt_chan,
  input  logic              ode_pin,
  output logic              drive_en
);
  logic [1:0]        sel_s;
  logic              strobe_s;
  logic              access_go;
  logic              ack_on;
  logic              q_pop;
  logic [CHAN_W-1:0] q_head;
  logic              q_empty;
  logic              q_full;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              ctrl_we;
  logic              rdata_en;

  mcu_port_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cs_n, ds_n}),
    .dout (sel_s)
  );

  assign strobe_s = (sel_s == 2'b00);

  mcu_port_handshake #(.ACK_DLY(ACK_DLY)) u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_s (strobe_s),
    .access_go(access_go),
    .ack_on   (ack_on)
  );

  mcu_port_irq_fifo #(.DEPTH(IRQ_DEPTH), .W(CHAN_W)) u_irqq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (evt_valid),
    .push_data(evt_chan),
    .pop      (q_pop),
    .head_data(q_head),
    .empty    (q_empty),
    .full     (q_full)
  );

  assign ctrl_we  = access_go && !rd_wr && (addr == CTRL_ADDR);
  assign rdata_en = access_go && rd_wr;
  assign q_pop    = rdata_en && (addr == IRQQ_ADDR);

  always_comb begin
    ctrl_d  = ctrl_we ? bus_wdata : ctrl_q;
    rdata_d = '0;
    if (addr == CTRL_ADDR) begin
      rdata_d = ctrl_q;
    end else if (addr == IRQQ_ADDR && !q_empty) begin
      rdata_d                = DATA_W'(q_head);
      rdata_d[VALID_BIT]     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (ctrl_we)  ctrl_q  <= ctrl_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata    = rdata_q;
  assign bus_rdata_oe = rd_wr && !cs_n && !ds_n && ack_on;
  assign ack_pull_lo  = ack_on;
  assign irq_pull_lo  = !q_empty;
  assign drive_en     = ode_pin && ctrl_q[ODE_BIT];

  // R8
  irq_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> irq_pull_lo);

  // R9
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pull_lo) |-> $past(q_pop));

  // R4
  no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_go |-> $past(sel_s == 2'b00));
endmodule

// File: tb/mcu_slave_port_bench.sv
module mcu_slave_port_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ds_n, rd_wr;
  logic [10:0] addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        bus_rdata_oe, ack_pull_lo, irq_pull_lo;
  logic        evt_valid;
  logic [2:0]  evt_chan;
  logic        ode_pin, drive_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_cycle = 1'b0;

  always #2.5 clk = ~clk;

  mcu_slave_port u_mcu_slave_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n), .rd_wr(rd_wr),
    .addr(addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .ack_pull_lo(ack_pull_lo),
    .irq_pull_lo(irq_pull_lo), .evt_valid(evt_valid), .evt_chan(evt_chan),
    .ode_pin(ode_pin), .drive_en(drive_en)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops an expected read value on each new acknowledge of a read
  initial begin
    logic prev_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (ack_pull_lo && !prev_ack && rd_cycle) begin
        if (exp_q.size() == 0) begin
          chk("scoreboard empty", 1, 0);
        end else begin
          chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
      prev_ack = ack_pull_lo;
    end
  end

  task automatic bus_access(bit rd, logic [10:0] a, logic [7:0] wd,
                            logic [7:0] exp, string tag, int hold = 0);
    int lat = 0;
    if (rd) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    rd_cycle = rd; rd_wr = rd; addr = a; bus_wdata = wd;
    cs_n = 1'b0; ds_n = 1'b0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (ack_pull_lo) begin lat = i; break; end
    end
    chk("R2 ack latency", lat, 4);
    chk("R7 data enable during ack", bus_rdata_oe, rd);
    for (int i = 0; i < hold; i++) @(negedge clk);
    if (hold > 0) chk("R3 ack held while strobe low", ack_pull_lo, 1);
    ds_n = 1'b1; cs_n = 1'b1;
    #0.1;
    chk("R7 data enable off with strobe", bus_rdata_oe, 0);
    lat = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (!ack_pull_lo) begin lat = i; break; end
    end
    chk("R3 ack release", (lat >= 1 && lat <= 3), 1);
    rd_cycle = 1'b0;
  endtask

  task automatic post_evt(logic [2:0] ch);
    @(negedge clk);
    evt_valid = 1'b1; evt_chan = ch;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk("watchdog expired", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; ds_n = 1'b1; rd_wr = 1'b1; addr = '0;
    bus_wdata = '0; evt_valid = 1'b0; evt_chan = '0; ode_pin = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ack released", ack_pull_lo, 0);
    chk("R1 irq released", irq_pull_lo, 0);
    chk("R1 data enable", bus_rdata_oe, 0);
    chk("R1 drive_en", drive_en, 0);
    bus_access(1, 11'h000, 8'h00, 8'h00, "R1 ctrl reset value");

    // R5 write/read control register; R6 drive enable from bit 6
    bus_access(0, 11'h000, 8'h5A, 8'h00, "R5 write");
    bus_access(1, 11'h000, 8'h00, 8'h5A, "R5 ctrl readback");
    chk("R6 drive_en pin=1 bit6=1", drive_en, 1);
    ode_pin = 1'b0; #0.1;
    chk("R6 drive_en pin=0 bit6=1", drive_en, 0);
    ode_pin = 1'b1;
    bus_access(0, 11'h000, 8'h1A, 8'h00, "R5 write");
    chk("R6 drive_en pin=1 bit6=0", drive_en, 0);

    // R5 unmapped address
    bus_access(0, 11'h123, 8'hFF, 8'h00, "R5 write");
    bus_access(1, 11'h123, 8'h00, 8'h00, "R5 unmapped reads zero");
    bus_access(1, 11'h000, 8'h00, 8'h1A, "R5 ctrl unchanged by unmapped write");

    // R4 strobe low with select high: no access
    @(negedge clk);
    rd_wr = 1'b0; addr = 11'h000; bus_wdata = 8'h77; cs_n = 1'b1; ds_n = 1'b0;
    begin
      int acks = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (ack_pull_lo) acks++;
      end
      chk("R4 no ack without select", acks, 0);
    end
    ds_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_access(1, 11'h000, 8'h00, 8'h1A, "R4 ctrl unchanged without select");

    // R8 / R9 interrupt queue
    post_evt(3'd3);
    chk("R8 irq after event", irq_pull_lo, 1);
    post_evt(3'd5);
    post_evt(3'd0);
    bus_access(1, 11'h001, 8'h00, 8'h83, "R8 first entry");
    chk("R9 irq held with entries left", irq_pull_lo, 1);
    // R3: strobe held low must not pop a second entry
    bus_access(1, 11'h001, 8'h00, 8'h85, "R8 second entry", 10);
    chk("R9 irq held with one entry left", irq_pull_lo, 1);
    bus_access(1, 11'h001, 8'h00, 8'h80, "R3 third entry after held strobe");
    chk("R9 irq released after last read", irq_pull_lo, 0);
    bus_access(1, 11'h001, 8'h00, 8'h00, "R9 empty read");

    // R10 fill past depth
    for (int i = 0; i < 17; i++) post_evt(3'(i % 8));
    for (int i = 0; i < 16; i++) begin
      bus_access(1, 11'h001, 8'h00, 8'h80 | 8'(i % 8), "R10 drain order");
      if (i == 14) chk("R10 irq before final read", irq_pull_lo, 1);
    end
    chk("R10 irq released after 16 reads", irq_pull_lo, 0);
    bus_access(1, 11'h001, 8'h00, 8'h00, "R10 17th event dropped");

    repeat (4) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule